// File: doc/BRIEF.md
# Shared Local Bus Ownership Arbiter

This block decides which master drives a shared local bus. The CPU owns the bus by default. There are also a number of alternate masters, three by default: a network controller, a DMA/peripheral controller and a backplane bridge. When an alternate master wants the bus, the arbiter raises an active-low request toward the CPU. It then waits for the CPU's active-low grant, which the CPU gives once it has finished any cycle in progress. Only then does the arbiter hand the bus to the most important alternate master that is asking at that moment. While any alternate master holds the bus, the arbiter drives an active-low acknowledge to the CPU.

When the owner signals release, the bus is idle for one cycle. After that cycle the arbiter either hands the bus directly to the next pending alternate master, without involving the CPU, or it gives the bus back to the CPU by dropping its request and acknowledge together. Priority is checked only at these handoff points, so an owner is never preempted. All outputs come from registers. Each input is sampled on a rising clock edge and takes effect on the outputs right after that edge.

Top module: `lbus_arbiter`

## Requirements
- R1: A synchronous active-high reset makes the CPU the owner: cpu_br_n = 1, bgack_n = 1 and gnt_o = 0 after the reset edge, including when reset arrives during an alternate master's tenure.
- R2: While the CPU owns the bus, any set bit of req_i sampled at an edge drives cpu_br_n low right after that edge.
- R3: No grant is issued while the arbiter waits with cpu_br_n low and cpu_bg_n is high. The grant appears right after the first edge at which cpu_bg_n is sampled low.
- R4: Fixed priority, with bit 0 of req_i highest and higher indices lower. Below every alternate master sits the CPU. A grant goes to the lowest-index requester that is set at the edge where the grant is decided.
- R5: A grant is held until rel_i has the bit of the current owner set. rel_i bits of other masters and newly arriving requests of any priority have no effect on gnt_o.
- R6: After the owner's release is sampled, gnt_o is zero for exactly one cycle while cpu_br_n and bgack_n stay low. If req_i is non-zero at the following edge, the highest-priority requester is granted directly.
- R7: If req_i is zero at the end of the idle cycle, cpu_br_n and bgack_n rise together after that edge and the CPU owns the bus again.
- R8: bgack_n is low exactly while an alternate master holds the bus or the bus is in the idle cycle that follows a release.
- R9: gnt_o is one-hot or zero in every cycle, and gnt_o never switches from one master to another without an intervening all-zero cycle.
- R10: If cpu_bg_n is sampled low while req_i is zero, no grant is issued and cpu_br_n returns high after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | NREQ | Alternate-master bus requests, bit 0 highest priority |
| rel_i | input | NREQ | Per-master release strobe, honoured only for the current owner |
| cpu_bg_n | input | 1 | Bus grant from the CPU, active low |
| cpu_br_n | output | 1 | Bus request to the CPU, active low |
| bgack_n | output | 1 | Grant acknowledge to the CPU, active low, held during alternate tenure |
| gnt_o | output | NREQ | One-hot grant to the alternate masters |

## Verification
If the state register goes wrong, the CPU handshake pins show it on the very next cycle. For example, cpu_br_n might fall with no request, or bgack_n might stay high under an active grant. A wrong owner register shows up as a grant to a lower-priority master or as a grant that changes without a release, and this is visible immediately on gnt_o. A missing idle cycle or a lost release appears one cycle after the release edge, either as back-to-back grants or as a grant that never drops.

// File: rtl/lba_pkg.sv
package lba_pkg;
  typedef enum logic [1:0] {
    ST_CPU     = 2'd0,
    ST_WAIT_BG = 2'd1,
    ST_OWNED   = 2'd2,
    ST_GAP     = 2'd3
  } lba_state_e;
endpackage

// File: rtl/lba_prio_pick.sv
module lba_prio_pick #(
  parameter int NREQ = 3
) (
  input  logic [NREQ-1:0] req,
  output logic [NREQ-1:0] pick,
  output logic            any
);
  logic [NREQ-1:0] seen;

  assign seen[0] = req[0];
  assign pick[0] = req[0];

  for (genvar i = 1; i < NREQ; i++) begin : g_chain
    assign pick[i] = req[i] & ~seen[i-1];
    assign seen[i] = req[i] | seen[i-1];
  end

  assign any = seen[NREQ-1];
endmodule

// File: rtl/lba_fsm.sv
module lba_fsm
  import lba_pkg::*;
#(
  parameter int NREQ = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            any_req,
  input  logic [NREQ-1:0] pick,
  input  logic [NREQ-1:0] rel_i,
  input  logic            cpu_bg_n,
  output logic            cpu_br_n,
  output logic            bgack_n,
  output logic [NREQ-1:0] gnt_o
);
  lba_state_e      state_q;
  logic [NREQ-1:0] owner_q;
  logic            rel_hit;

  assign rel_hit = |(owner_q & rel_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_CPU;
      owner_q <= '0;
    end else begin
      case (state_q)
        ST_CPU: begin
          if (any_req) state_q <= ST_WAIT_BG;
        end
        ST_WAIT_BG: begin
          if (!cpu_bg_n) begin
            if (any_req) begin
              state_q <= ST_OWNED;
              owner_q <= pick;
            end else begin
              state_q <= ST_CPU;
            end
          end
        end
        ST_OWNED: begin
          if (rel_hit) begin
            state_q <= ST_GAP;
            owner_q <= '0;
          end
        end
        ST_GAP: begin
          if (any_req) begin
            state_q <= ST_OWNED;
            owner_q <= pick;
          end else begin
            state_q <= ST_CPU;
          end
        end
        default: begin
          state_q <= ST_CPU;
          owner_q <= '0;
        end
      endcase
    end
  end

  assign cpu_br_n = (state_q == ST_CPU);
  assign bgack_n  = !((state_q == ST_OWNED) || (state_q == ST_GAP));
  assign gnt_o    = owner_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o)); // R9
  AST_GNT_NEEDS_BG: assert property (@(posedge clk) disable iff (rst)
    ($rose(|gnt_o) && $past(bgack_n)) |-> $past(!cpu_bg_n)); // R3
  AST_GNT_ACKED: assert property (@(posedge clk) disable iff (rst)
    (|gnt_o) |-> (!bgack_n && !cpu_br_n)); // R8
  AST_NO_DIRECT_SWITCH: assert property (@(posedge clk) disable iff (rst)
    (|gnt_o) |=> ((gnt_o == $past(gnt_o)) || (gnt_o == '0))); // R9
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    ((|gnt_o) && !(|(gnt_o & rel_i))) |=> (gnt_o == $past(gnt_o))); // R5
  AST_RETURN_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $rose(bgack_n) |-> $rose(cpu_br_n)); // R7
endmodule

// File: rtl/lbus_arbiter.sv
module lbus_arbiter #(
  parameter int NREQ = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req_i,
  input  logic [NREQ-1:0] rel_i,
  input  logic            cpu_bg_n,
  output logic            cpu_br_n,
  output logic            bgack_n,
  output logic [NREQ-1:0] gnt_o
);
  logic [NREQ-1:0] pick;
  logic            any_req;

  lba_prio_pick #(.NREQ(NREQ)) u_pick (
    .req  (req_i),
    .pick (pick),
    .any  (any_req)
  );

  lba_fsm #(.NREQ(NREQ)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .any_req  (any_req),
    .pick     (pick),
    .rel_i    (rel_i),
    .cpu_bg_n (cpu_bg_n),
    .cpu_br_n (cpu_br_n),
    .bgack_n  (bgack_n),
    .gnt_o    (gnt_o)
  );

  AST_BR_BEFORE_GNT: assert property (@(posedge clk) disable iff (rst)
    (!cpu_br_n && bgack_n) |-> (gnt_o == '0)); // R3
endmodule

// File: tb/tb_lbus_arbiter.sv
module tb_lbus_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] req_i = '0;
  logic [2:0] rel_i = '0;
  logic       cpu_bg_n = 1'b1;
  logic       cpu_br_n, bgack_n;
  logic [2:0] gnt_o;
  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lbus_arbiter #(.NREQ(3)) dut (
    .clk(clk), .rst(rst), .req_i(req_i), .rel_i(rel_i),
    .cpu_bg_n(cpu_bg_n), .cpu_br_n(cpu_br_n), .bgack_n(bgack_n), .gnt_o(gnt_o)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic [2:0] req;
    logic [2:0] rel;
    logic       bg_n;
    logic       br_n;
    logic       ack_n;
    logic [2:0] gnt;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  3'b000, 3'b000, 1'b1, 1'b1, 1'b1, 3'b000}, // R1 idle CPU
    '{4'd2,  3'b100, 3'b000, 1'b1, 1'b0, 1'b1, 3'b000}, // R2 request raised
    '{4'd3,  3'b110, 3'b000, 1'b1, 1'b0, 1'b1, 3'b000}, // R3 wait for bg
    '{4'd4,  3'b110, 3'b000, 1'b0, 1'b0, 1'b0, 3'b010}, // R4 bit1 wins
    '{4'd5,  3'b111, 3'b000, 1'b0, 1'b0, 1'b0, 3'b010}, // R5 no preempt
    '{4'd5,  3'b111, 3'b101, 1'b0, 1'b0, 1'b0, 3'b010}, // R5 foreign release
    '{4'd6,  3'b101, 3'b010, 1'b0, 1'b0, 1'b0, 3'b000}, // R6 idle gap
    '{4'd6,  3'b101, 3'b000, 1'b0, 1'b0, 1'b0, 3'b001}, // R6 direct handoff
    '{4'd8,  3'b100, 3'b001, 1'b0, 1'b0, 1'b0, 3'b000}, // R8 ack held in gap
    '{4'd4,  3'b100, 3'b000, 1'b0, 1'b0, 1'b0, 3'b100}, // R4 lowest priority
    '{4'd6,  3'b000, 3'b100, 1'b0, 1'b0, 1'b0, 3'b000}, // R6 gap again
    '{4'd7,  3'b000, 3'b000, 1'b0, 1'b1, 1'b1, 3'b000}, // R7 back to CPU
    '{4'd7,  3'b000, 3'b000, 1'b1, 1'b1, 1'b1, 3'b000}, // R7 stays CPU
    '{4'd2,  3'b001, 3'b000, 1'b1, 1'b0, 1'b1, 3'b000}, // R2 request
    '{4'd3,  3'b000, 3'b000, 1'b1, 1'b0, 1'b1, 3'b000}, // R3 still waiting
    '{4'd10, 3'b000, 3'b000, 1'b0, 1'b1, 1'b1, 3'b000}, // R10 withdrawn
    '{4'd9,  3'b000, 3'b000, 1'b1, 1'b1, 1'b1, 3'b000}  // R9 quiet
  };

  task automatic check(string tag, logic [2:0] eg, logic ebr, logic eack);
    nvec++;
    if (gnt_o !== eg || cpu_br_n !== ebr || bgack_n !== eack) begin
      nbad++;
      $display("FAIL %s: gnt=%b br_n=%b ack_n=%b expected gnt=%b br_n=%b ack_n=%b",
               tag, gnt_o, cpu_br_n, bgack_n, eg, ebr, eack);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset state", 3'b000, 1'b1, 1'b1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_i    = VEC[i].req;
      rel_i    = VEC[i].rel;
      cpu_bg_n = VEC[i].bg_n;
      step();
      check($sformatf("R%0d vector %0d", VEC[i].rq, i), VEC[i].gnt, VEC[i].br_n, VEC[i].ack_n);
    end

    // R4 simultaneous requests at the bg edge: bit0 wins
    @(negedge clk); req_i = 3'b111; rel_i = '0; cpu_bg_n = 1'b1;
    step();
    @(negedge clk); cpu_bg_n = 1'b0;
    step();
    check("R4 all request", 3'b001, 1'b0, 1'b0);

    // R1 reset during a tenure
    @(negedge clk); rst = 1'b1;
    step();
    check("R1 reset mid tenure", 3'b000, 1'b1, 1'b1);
    @(negedge clk); rst = 1'b0; req_i = '0; cpu_bg_n = 1'b1;
    step();
    check("R1 idle after reset", 3'b000, 1'b1, 1'b1);

    // R3 bg low while CPU owns and nothing requested: ignored
    @(negedge clk); cpu_bg_n = 1'b0;
    step();
    check("R3 stray bg ignored", 3'b000, 1'b1, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule